// File: doc/BRIEF.md
# Split-capable load/store access unit

This unit sits between a core's load/store port and a word-wide synchronous data memory. The core hands it one request at a time: a byte address, an access size (byte, halfword or word), a load or store flag, a sign-extend flag for loads and a byte-order select. The unit works out whether the request is aligned, then drives the memory with word-aligned addresses only.

An aligned request costs one memory word access. A misaligned request always costs exactly two accesses in consecutive cycles: the word holding the lowest byte first, then the word four bytes above it. For loads the bytes of both words are gathered and ordered as little or big endian, then extended to 32 bits. For stores each of the two writes carries byte enables only for the bytes of the access that lie in that word. Completion is signalled by a one-cycle `done` pulse with the load result alongside.

The request side is valid/ready. `req_ready` is high only while the unit is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a request is in flight `req_ready` is low, so a waiting core simply holds `req_valid` and its request fields stable and is taken on the first edge after `done`. The memory side is plain: `mem_req` marks a cycle with an access, and `mem_rdata` carries the addressed word in the cycle after.

Top module: `lsu_split`

## Requirements
- R1: During and right after reset `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: `req_ready` is 1 exactly when the unit is idle; request inputs presented while it is 0 are ignored and cause no memory access.
- R3: A request with byte address A and size n bytes (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) is aligned when A mod n is 0; it then makes exactly one memory access, at A with its two low bits cleared.
- R4: A misaligned request makes exactly two memory accesses in back-to-back cycles, the first at the word address of A, the second at that address plus 4.
- R5: `done` is high in the third cycle after the accepting edge for an aligned request and in the fourth for a misaligned one (one cycle after the last memory response).
- R6: Byte address B lives in memory lane B mod 4, lane i being bits 8i+7..8i of a word. With `req_big` = 0, the byte at the lowest address of the access is the least significant byte of the value.
- R7: With `req_big` = 1, the byte at the lowest address of the access is the most significant byte of the value.
- R8: A byte load returns the byte with bits 31..8 copied from bit 7 when `req_signed` is 1, and zero when it is 0.
- R9: A halfword load returns the value with bits 31..16 copied from bit 15 when `req_signed` is 1, and zero when it is 0.
- R10: A store writes exactly the n bytes of the access, each write driving byte enables only for bytes inside that word (a second write may carry none); every other memory byte is unchanged.
- R11: `done` lasts exactly one cycle; with it `rdata` holds the load value, or zero for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_store | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_big | input | 1 | 1 big-endian, 0 little-endian |
| req_wdata | input | 32 | Store value, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load result, valid with done |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data in lane order |
| mem_rdata | input | 32 | Read word, due the cycle after the access |

## Verification
Every scenario counts the clock edges from the accepting edge and expects `done` at edge three for an aligned request and edge four for a split one, sampling on the falling edge so the registered pulse is stable. Memory accesses are logged on each rising edge and compared, in number, order and address, against the split rule before the pulse is due. Load values and the memory image after a store are checked in the falling-edge slot where `done` is high, and the slot after that must show `done` low again.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

  // access width in bytes for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
// Places the store value onto the lanes of two consecutive words.
module lsu_lane_map #(
  parameter int NB = 4,
  localparam int OW = $clog2(NB),
  localparam int RW = OW + 2
) (
  input  logic [OW-1:0]      off,
  input  logic [OW:0]        nbytes,
  input  logic               big,
  input  logic [8*NB-1:0]    wdata,
  output logic [2*NB-1:0]    be,
  output logic [16*NB-1:0]   lanes
);

  for (genvar j = 0; j < 2 * NB; j++) begin : g_lane
    logic [RW-1:0] rel;
    logic [RW-1:0] pick;
    logic          hit;
    logic [OW-1:0] src;

    always_comb begin
      rel  = RW'(j) - RW'(off);
      hit  = (RW'(j) >= RW'(off)) && (rel < RW'(nbytes));
      pick = big ? (RW'(nbytes) - RW'(1) - rel) : rel;
      src  = pick[OW-1:0];
    end

    assign be[j]          = hit;
    assign lanes[8*j +: 8] = hit ? wdata[{src, 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_load_merge.sv
// Gathers the accessed bytes from two words, orders and extends them.
module lsu_load_merge #(
  parameter int NB = 4,
  localparam int OW = $clog2(NB),
  localparam int RW = OW + 2
) (
  input  logic [8*NB-1:0]  w_lo,
  input  logic [8*NB-1:0]  w_hi,
  input  logic [OW-1:0]    off,
  input  logic [OW:0]      nbytes,
  input  logic             big,
  input  logic             sext,
  output logic [8*NB-1:0]  value
);

  logic [16*NB-1:0] lanes;
  logic [NB-1:0]    msb;
  logic [NB-1:0]    used;
  logic [8*NB-1:0]  raw;
  logic             fill;

  assign lanes = {w_hi, w_lo};

  for (genvar m = 0; m < NB; m++) begin : g_byte
    logic [RW-1:0] k;
    logic [RW-1:0] pos;

    always_comb begin
      k   = big ? (RW'(nbytes) - RW'(1) - RW'(m)) : RW'(m);
      pos = RW'(off) + k;
    end

    assign used[m]         = RW'(m) < RW'(nbytes);
    assign raw[8*m +: 8]   = used[m] ? lanes[{pos, 3'b000} +: 8] : 8'h00;
    assign msb[m]          = raw[8*m+7];
    assign value[8*m +: 8] = used[m] ? raw[8*m +: 8] : {8{fill}};
  end

  assign fill = sext && msb[OW'(nbytes - 1'b1)];

endmodule

// File: rtl/lsu_split.sv
module lsu_split #(
  parameter int AW = 16,
  localparam int NB = 4,
  localparam int DW = 8 * NB,
  localparam int OW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_store,
  input  logic          req_signed,
  input  logic          req_big,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [NB-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import lsu_pkg::*;

  state_e        state;
  logic [AW-1:0] addr_q;
  logic [OW:0]   nbytes_q;
  logic          store_q;
  logic          signed_q;
  logic          big_q;
  logic [DW-1:0] wdata_q;
  logic          split_q;
  logic [DW-1:0] lo_word_q;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  logic          take;
  logic [OW:0]   nb_in;
  logic          mis_in;
  logic [AW-1:0] base_addr;
  logic [2*NB-1:0] be_all;
  logic [2*DW-1:0] lanes_all;
  logic [DW-1:0] merged;
  logic [DW-1:0] w_lo_sel;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign nb_in     = size_bytes(req_size);
  assign mis_in    = (req_addr[OW-1:0] & OW'(nb_in - 1'b1)) != '0;
  assign base_addr = {addr_q[AW-1:OW], {OW{1'b0}}};

  lsu_lane_map #(.NB(NB)) u_lanes (
    .off    (addr_q[OW-1:0]),
    .nbytes (nbytes_q),
    .big    (big_q),
    .wdata  (wdata_q),
    .be     (be_all),
    .lanes  (lanes_all)
  );

  // aligned: only the response now on mem_rdata matters
  assign w_lo_sel = split_q ? lo_word_q : mem_rdata;

  lsu_load_merge #(.NB(NB)) u_merge (
    .w_lo   (w_lo_sel),
    .w_hi   (mem_rdata),
    .off    (addr_q[OW-1:0]),
    .nbytes (nbytes_q),
    .big    (big_q),
    .sext   (signed_q),
    .value  (merged)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = base_addr;
    mem_be    = '0;
    mem_wdata = '0;
    case (state)
      ST_LO: begin
        mem_req   = 1'b1;
        mem_we    = store_q;
        mem_be    = store_q ? be_all[NB-1:0] : '0;
        mem_wdata = lanes_all[DW-1:0];
      end
      ST_HI: begin
        mem_req   = 1'b1;
        mem_we    = store_q;
        mem_addr  = base_addr + AW'(NB);
        mem_be    = store_q ? be_all[2*NB-1:NB] : '0;
        mem_wdata = lanes_all[2*DW-1:DW];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      nbytes_q  <= '0;
      store_q   <= 1'b0;
      signed_q  <= 1'b0;
      big_q     <= 1'b0;
      wdata_q   <= '0;
      split_q   <= 1'b0;
      lo_word_q <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            addr_q   <= req_addr;
            nbytes_q <= nb_in;
            store_q  <= req_store;
            signed_q <= req_signed;
            big_q    <= req_big;
            wdata_q  <= req_wdata;
            split_q  <= mis_in;
            state    <= ST_LO;
          end
        end
        ST_LO: state <= split_q ? ST_HI : ST_FIN;
        ST_HI: begin
          lo_word_q <= mem_rdata;
          state     <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          rdata_q <= store_q ? '0 : merged;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R11

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req) else $error("access while idle"); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready) else $error("done while busy"); // R2

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)) else $error("unaligned memory address"); // R3

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == AW'($past(mem_addr) + AW'(4))))
    else $error("second access not at next word"); // R4

  AST_WRITE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req) else $error("write strobe without access"); // R10

  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!mem_req && !req_ready)) else $error("done without response cycle"); // R5

endmodule

bind lsu_split lsu_split_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_lsu_split.sv
`timescale 1ns/1ps
module tb_lsu_split;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic        req_store;
  logic        req_signed;
  logic        req_big;
  logic [31:0] req_wdata;
  logic        done;
  logic [31:0] rdata;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem [64];
  int          acc_cnt;
  logic [15:0] acc_addr [4];

  always #4 clk = ~clk;

  lsu_split #(.AW(AW)) dut (.*);

  // memory model and access log
  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[7:2]][8*i +: 8] = mem_wdata[8*i +: 8];
      if (acc_cnt < 4) acc_addr[acc_cnt] = mem_addr;
      acc_cnt = acc_cnt + 1;
    end
  end

  function automatic logic [7:0] getb(input int a);
    return mem[(a >> 2) & 63][8*(a & 3) +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request; checks timing, accesses and result
  task automatic do_req(input int a, input logic [1:0] sz, input bit st,
                        input bit sg, input bit bg, input logic [31:0] wd,
                        input string rtag);
    int n, edges;
    bit mis;
    logic [31:0] expv;
    logic [7:0] exb [16];
    logic [7:0] b;
    n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mis = (a % n) != 0;
    expv = '0;
    for (int k = 0; k < n; k++) begin
      b = getb(a + k);
      if (bg) expv[8*(n-1-k) +: 8] = b; else expv[8*k +: 8] = b;
    end
    if (sg && n < 4 && expv[8*n-1]) for (int m = n; m < 4; m++) expv[8*m +: 8] = 8'hFF;
    for (int i = 0; i < 16; i++) exb[i] = getb(a - 4 + i);
    for (int k = 0; k < n; k++)
      exb[4 + k] = bg ? wd[8*(n-1-k) +: 8] : wd[8*k +: 8];

    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a[15:0]; req_size = sz; req_store = st;
    req_signed = sg; req_big = bg; req_wdata = wd;
    acc_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    edges = 1;
    chk(req_ready === 1'b0, "R2", "ready while busy", {31'b0, req_ready}, 32'd0);
    while (done !== 1'b1 && edges < 20) begin
      @(negedge clk);
      edges++;
    end
    chk(edges == (mis ? 4 : 3), mis ? "R5" : "R5", "done latency", edges, mis ? 4 : 3);
    chk(acc_cnt == (mis ? 2 : 1), mis ? "R4" : "R3", "access count", acc_cnt, mis ? 2 : 1);
    chk(acc_addr[0] == 16'(a & ~3), mis ? "R4" : "R3", "first word address",
        {16'b0, acc_addr[0]}, a & ~3);
    if (mis)
      chk(acc_addr[1] == 16'((a & ~3) + 4), "R4", "second word address",
          {16'b0, acc_addr[1]}, (a & ~3) + 4);
    if (st) begin
      chk(rdata === 32'd0, "R11", "store rdata", rdata, 32'd0);
      for (int i = 0; i < 16; i++)
        chk(getb(a - 4 + i) === exb[i], "R10", $sformatf("byte at %0d", a - 4 + i),
            {24'b0, getb(a - 4 + i)}, {24'b0, exb[i]});
    end else begin
      chk(rdata === expv, rtag, "load value", rdata, expv);
    end
    @(negedge clk);
    chk(done === 1'b0, "R11", "done pulse width", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1", "reset ready", {31'b0, req_ready}, 32'd1);
    chk(done === 1'b0, "R1", "reset done", {31'b0, done}, 32'd0);
    chk(mem_req === 1'b0, "R1", "reset mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_aligned_words;
    do_req(16, 2'd2, 0, 0, 0, 0, "R6");
    do_req(20, 2'd2, 0, 0, 1, 0, "R7");
    do_req(24, 2'd3, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_bytes;
    for (int o = 0; o < 4; o++) begin
      do_req(40 + o, 2'd0, 0, 1, 0, 0, "R8");
      do_req(40 + o, 2'd0, 0, 0, 1, 0, "R8");
    end
  endtask

  task automatic t_halves;
    do_req(48, 2'd1, 0, 1, 0, 0, "R9");
    do_req(48, 2'd1, 0, 0, 0, 0, "R9");
    do_req(50, 2'd1, 0, 1, 1, 0, "R9");
    do_req(49, 2'd1, 0, 1, 0, 0, "R9");
    do_req(51, 2'd1, 0, 0, 1, 0, "R7");
    do_req(51, 2'd1, 0, 1, 0, 0, "R6");
  endtask

  task automatic t_split_words;
    do_req(61, 2'd2, 0, 0, 0, 0, "R6");
    do_req(62, 2'd2, 0, 0, 1, 0, "R7");
    do_req(67, 2'd2, 0, 0, 0, 0, "R6");
    do_req(67, 2'd2, 0, 0, 1, 0, "R7");
  endtask

  task automatic t_stores;
    do_req(80, 2'd0, 1, 0, 0, 32'hA5A5_A53C, "R10");
    do_req(86, 2'd2, 1, 0, 1, 32'h1122_3344, "R10");
    do_req(93, 2'd1, 1, 0, 0, 32'h0000_BEEF, "R10");
    do_req(99, 2'd1, 1, 0, 1, 32'h0000_CAFE, "R10");
    do_req(105, 2'd2, 1, 0, 0, 32'hDEAD_0123, "R10");
    do_req(104, 2'd2, 1, 0, 0, 32'h7654_3210, "R10");
    do_req(105, 2'd2, 0, 0, 0, 0, "R6");
  endtask

  // request fields change while busy: no extra access, nothing taken
  task automatic t_busy_ignore;
    int edges;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'd128; req_size = 2'd2; req_store = 0;
    req_signed = 0; req_big = 0; req_wdata = '0;
    acc_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'd141; req_store = 1; req_wdata = 32'hFFFF_FFFF;
    edges = 1;
    while (done !== 1'b1 && edges < 20) begin
      @(negedge clk);
      edges++;
    end
    req_valid = 1'b0;
    chk(acc_cnt == 1, "R2", "accesses while busy", acc_cnt, 1);
    chk(acc_addr[0] == 16'd128, "R2", "busy address", {16'b0, acc_addr[0]}, 128);
    chk(rdata === mem[32], "R2", "busy result", rdata, mem[32]);
    @(negedge clk);
    @(negedge clk);
    chk(acc_cnt == 1 && mem_req === 1'b0, "R2", "no late acceptance", acc_cnt, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h8170_F00D;
    mem_rdata = '0;
    acc_cnt = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_store = 0; req_signed = 0; req_big = 0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_aligned_words;
    t_bytes;
    t_halves;
    t_split_words;
    t_stores;
    t_busy_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule